// File: doc/BRIEF.md
# Bus Target Event Status and Interrupt Unit

This block sits behind the front end of a serial-bus target. It keeps the target's event status and turns it into one interrupt line for a processor. The front end sends one-cycle pulses when it sees a start condition, an address match or a stop condition. It also drives three levels: bus busy, receive data pending and transmit space available. The block holds the three pulsed events in sticky bits and passes the three levels through as live bits.

Software reads and writes the block through a simple register port. It clears a sticky bit by writing 1 to that bit. It turns interrupt sources on through one register and off through another. It reads a masked view of the status, and that masked view drives the IRQ output.

A configuration bit can restrict the start and stop sticky bits so that they record only while the address-matched flag is set. With that restriction, the start and stop bits mark the edges of messages addressed to this target.

Top module: `bus_evt_status`

## Requirements
- R1: After reset, the sticky bits, the enable register, the configuration register and `irq_o` are all 0.
- R2: A pulse on `start_pulse_i` sets status bit 8, and a pulse on `match_pulse_i` sets status bit 9. The new value is readable at register address 0 in the cycle after the pulse.
- R3: A pulse on `stop_pulse_i` sets status bit 10 one cycle later than a start or match pulse would set its bit. This happens only if, in the cycle after the stop pulse, `start_pulse_i` is low and `bus_busy_i` is low. A stop followed at once by a new start leaves bit 10 clear.
- R4: Writing to address 0 clears each sticky bit (8, 9, 10) that has a 1 in the write data. Bits written 0 are not changed.
- R5: If a set event and a clearing write hit the same sticky bit in the same cycle, the bit ends up set.
- R6: Configuration register address 4, bit 0, turns on match gating. While match gating is 1, the start and stop bits can be set only while sticky bit 9 is already 1. While it is 0, every start and stop is recorded. Address 4 reads back what was written to bit 0.
- R7: Status bit 0 equals `bus_busy_i`, bit 11 equals `rx_pend_i` and bit 12 equals `tx_room_i`, with no delay. Writes to address 0 do not change these bits.
- R8: Writing 1 to a bit in the range 8 to 12 at address 1 turns that interrupt source on. Writing 1 to the same bit at address 2 turns it off. Writing 0 to either address changes nothing. Reading address 1 returns the enables in bits 8 to 12.
- R9: Address 3 returns the status bits 8 to 12 ANDed with the enable bits. `irq_o` is the OR of those masked bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_pulse_i | input | 1 | One-cycle pulse: start condition seen |
| match_pulse_i | input | 1 | One-cycle pulse: own address matched |
| stop_pulse_i | input | 1 | One-cycle pulse: stop condition seen |
| bus_busy_i | input | 1 | Level: 1 while the bus is not stopped |
| rx_pend_i | input | 1 | Level: receive data waiting |
| tx_room_i | input | 1 | Level: transmit buffer not full |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |

## Verification
A sticky bit that is stuck, lost or wrongly gated shows up in the status read one cycle after the event. For a stop event it shows up two cycles after the event. The same fault reaches `irq_o` in that cycle whenever the bit's source is enabled. A corrupted enable shows up at once in the address 1 readback and in the masked read at address 3. Both observations come before the next stimulus, so a fault cannot hide behind a later event or clear.

// File: rtl/bus_evt_pkg.sv
package bus_evt_pkg;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned STICKY_N = 3;   // start, match, stop
  localparam int unsigned SRC_N   = 5;    // interruptible bits 8..12
  localparam int unsigned SRC_LSB = 8;
  localparam int unsigned BUSY_BIT = 0;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 3'd0,
    A_EN_SET = 3'd1,
    A_EN_CLR = 3'd2,
    A_MASKED = 3'd3,
    A_CONFIG = 3'd4
  } reg_addr_e;

  // sticky indices
  localparam int unsigned S_START = 0;
  localparam int unsigned S_MATCH = 1;
  localparam int unsigned S_STOP  = 2;
endpackage

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;   // set has priority
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/enable_reg.sv
module enable_reg #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] wbits_i,
  output logic [N-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_o <= '0;
    else if (set_we_i) en_o <= en_o | wbits_i;
    else if (clr_we_i) en_o <= en_o & ~wbits_i;
  end
endmodule

// File: rtl/bus_evt_status.sv
module bus_evt_status
  import bus_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_pulse_i,
  input  logic              match_pulse_i,
  input  logic              stop_pulse_i,
  input  logic              bus_busy_i,
  input  logic              rx_pend_i,
  input  logic              tx_room_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [STICKY_N-1:0] sticky_q, sticky_set, sticky_clr;
  logic [SRC_N-1:0]    en_q, src_lvl, masked;
  logic                gate_q, stop_q, pass;
  logic [SRC_N-1:0]    wsrc;
  logic [DATA_W-1:0]   status;

  assign wsrc = reg_wdata_i[SRC_LSB +: SRC_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      stop_q <= stop_pulse_i;
      if (reg_we_i && reg_addr_i == A_CONFIG) gate_q <= reg_wdata_i[0];
    end
  end

  // gated edges record only inside this target's own message
  assign pass = !gate_q || sticky_q[S_MATCH];

  always_comb begin
    sticky_set          = '0;
    sticky_set[S_START] = start_pulse_i && pass;
    sticky_set[S_MATCH] = match_pulse_i;
    // stop counts only if the bus is still stopped a cycle later
    sticky_set[S_STOP]  = stop_q && !start_pulse_i && !bus_busy_i && pass;
    sticky_clr = (reg_we_i && reg_addr_i == A_STATUS) ?
                 wsrc[STICKY_N-1:0] : '0;
  end

  sticky_bank #(.N(STICKY_N)) u_sticky (
    .clk_i, .rst_ni, .set_i(sticky_set), .clr_i(sticky_clr), .q_o(sticky_q)
  );

  enable_reg #(.N(SRC_N)) u_en (
    .clk_i, .rst_ni,
    .set_we_i(reg_we_i && reg_addr_i == A_EN_SET),
    .clr_we_i(reg_we_i && reg_addr_i == A_EN_CLR),
    .wbits_i (wsrc),
    .en_o    (en_q)
  );

  assign src_lvl = {tx_room_i, rx_pend_i, sticky_q};
  assign masked  = src_lvl & en_q;
  assign irq_o   = |masked;

  always_comb begin
    status = '0;
    status[BUSY_BIT] = bus_busy_i;
    status[SRC_LSB +: SRC_N] = src_lvl;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_STATUS: reg_rdata_o = status;
      A_EN_SET: reg_rdata_o[SRC_LSB +: SRC_N] = en_q;
      A_MASKED: reg_rdata_o[SRC_LSB +: SRC_N] = masked;
      A_CONFIG: reg_rdata_o[0] = gate_q;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/bus_evt_status_chk.sv
module bus_evt_status_chk
  import bus_evt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_pulse_i,
  input logic              match_pulse_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              irq_o,
  input logic [STICKY_N-1:0] sticky_q,
  input logic [SRC_N-1:0]  en_q,
  input logic              gate_q
);
  a_r2_match_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_pulse_i |=> sticky_q[S_MATCH]);

  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_pulse_i && (!gate_q || sticky_q[S_MATCH])) |=> sticky_q[S_START]);

  a_r4_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_STATUS && reg_wdata_i[SRC_LSB+S_START] &&
     !start_pulse_i) |=> !sticky_q[S_START]);

  a_r6_gated_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_q && !sticky_q[S_MATCH] && !sticky_q[S_START]) |=> !sticky_q[S_START]);

  a_r8_en_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_EN_SET && reg_wdata_i[SRC_LSB]) |=> en_q[0]);

  a_r9_irq_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_q != '0));
endmodule

bind bus_evt_status bus_evt_status_chk u_chk (.*);

// File: tb/sim_bus_evt_status.sv
`timescale 1ns/1ps
module sim_bus_evt_status;
  logic clk = 1'b0, rst_n = 1'b0;
  logic st = 0, mt = 0, sp = 0, busy = 0, rx = 0, tx = 0, we = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;   // 125 MHz

  bus_evt_status u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_pulse_i(st), .match_pulse_i(mt),
    .stop_pulse_i(sp), .bus_busy_i(busy), .rx_pend_i(rx), .tx_room_i(tx),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    addr = a; #1; chk(req, rdata, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1; addr = a; wdata = d; cyc(); we = 0; wdata = 0;
  endtask

  task automatic pulse(ref logic p);
    p = 1; cyc(); p = 0;
  endtask

  task automatic t_reset;
    rd("R1 status", 3'd0, 32'h0);
    rd("R1 enables", 3'd1, 32'h0);
    rd("R1 config", 3'd4, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_sticky;
    pulse(st); rd("R2 start", 3'd0, 32'h100);
    pulse(mt); rd("R2 match", 3'd0, 32'h300);
    sp = 1; cyc(); sp = 0;
    rd("R3 stop not yet", 3'd0, 32'h300);
    cyc(); rd("R3 stop", 3'd0, 32'h700);
    wr(3'd0, 32'h200); rd("R4 clear match only", 3'd0, 32'h500);
    wr(3'd0, 32'h0);   rd("R4 zero write", 3'd0, 32'h500);
    wr(3'd0, 32'h500); rd("R4 clear rest", 3'd0, 32'h0);
  endtask

  task automatic t_set_wins;
    st = 1; we = 1; addr = 3'd0; wdata = 32'h100; cyc();
    st = 0; we = 0; wdata = 0;
    rd("R5 set beats clear", 3'd0, 32'h100);
    wr(3'd0, 32'h100);
  endtask

  task automatic t_quick_restart;
    busy = 1; sp = 1; cyc(); sp = 0; st = 1; cyc(); st = 0;
    rd("R3 quick restart no stop", 3'd0, 32'h101);
    wr(3'd0, 32'h100);
    sp = 1; cyc(); sp = 0; cyc();
    rd("R3 busy blocks stop", 3'd0, 32'h1);
    busy = 0;
  endtask

  task automatic t_gate;
    wr(3'd4, 32'h1); rd("R6 config readback", 3'd4, 32'h1);
    pulse(st); sp = 1; cyc(); sp = 0; cyc();
    rd("R6 gated out", 3'd0, 32'h0);
    pulse(mt); pulse(st);
    rd("R6 start inside msg", 3'd0, 32'h300);
    sp = 1; cyc(); sp = 0; cyc();
    rd("R6 stop inside msg", 3'd0, 32'h700);
    wr(3'd0, 32'h700); wr(3'd4, 32'h0);
  endtask

  task automatic t_live;
    busy = 1; rx = 1; tx = 0; rd("R7 busy rx", 3'd0, 32'h801);
    wr(3'd0, 32'h1FFF); rd("R7 not writable", 3'd0, 32'h801);
    busy = 0; rx = 0; tx = 1; rd("R7 tx", 3'd0, 32'h1000);
    tx = 0;
  endtask

  task automatic t_enables;
    wr(3'd1, 32'h500); rd("R8 set", 3'd1, 32'h500);
    wr(3'd1, 32'h0);   rd("R8 zero set", 3'd1, 32'h500);
    wr(3'd2, 32'h0);   rd("R8 zero clr", 3'd1, 32'h500);
    wr(3'd2, 32'h100); rd("R8 clr", 3'd1, 32'h400);
    chk("R9 irq idle", {31'b0, irq}, 0);
    sp = 1; cyc(); sp = 0; cyc();
    rd("R9 masked stop", 3'd3, 32'h400);
    chk("R9 irq stop", {31'b0, irq}, 1);
    pulse(st); rd("R9 start unmasked hidden", 3'd3, 32'h400);
    wr(3'd2, 32'h400); chk("R9 irq off", {31'b0, irq}, 0);
    wr(3'd1, 32'h800); rx = 1; #1;
    chk("R9 irq rx", {31'b0, irq}, 1);
    rd("R9 masked rx", 3'd3, 32'h800);
    rx = 0; #1; chk("R9 irq rx gone", {31'b0, irq}, 0);
  endtask

  initial begin : watchdog
    #400000;
    n_chk++; n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    cyc(2); rst_n = 1; cyc();
    t_reset();
    t_sticky();
    t_set_wins();
    t_quick_restart();
    t_gate();
    t_live();
    t_enables();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule